// File: doc/BRIEF.md
# Serially Programmed Channel Selector Control

This block holds the digital control for a bank of analog channel switches that a host programs over a three-wire, write-only serial port. The port has an active-low frame input, a serial clock and a data line. While a transfer is armed, the block samples data on each falling serial-clock edge into an 8-bit shift register. Once the eighth falling edge has been taken, it decodes the word and loads registered one-hot enable vectors that drive the switches. It does not wait for the frame line to rise before it does so.

The parameter `DUAL_BANK` picks one of two variants. With `DUAL_BANK=1`, the block serves two 16-channel banks. Each bank has its own active-low select, and one address closes the same channel in every selected bank. With `DUAL_BANK=0`, there is a single 32-channel bank with one active-low select. In both variants the word carries an all-off bit. A deselected bank keeps whatever it held before. The serial inputs are sampled with the system clock `clk`, so every serial-clock level must be held for at least one `clk` cycle.

The control state machine has four states. IDLE waits for the frame line to go low. SHIFT takes falling serial-clock edges and counts them. COMMIT lasts one cycle, in which the bank registers load. HOLD ignores further edges. The transitions are as follows. IDLE→SHIFT happens when the frame line is low. SHIFT→COMMIT happens on the eighth falling edge. COMMIT→HOLD happens unconditionally. HOLD→IDLE happens when the frame line is high.

Top module: `serial_mux_ctl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, every bit of `sw_a` and `sw_b` is 0.
- R2: Falling serial-clock edges that occur while the block is idle with `frame_n` high are not shifted or counted, so they have no effect on a later transfer.
- R3: Data is sampled on the falling edge of `sclk`, most significant bit first. The first bit taken becomes bit 7 of the word.
- R4: Both outputs keep their values through the first seven falling edges of a transfer. The outputs update two `clk` cycles after the eighth edge is sampled, while `frame_n` is still low.
- R5: A low pulse on `frame_n` of two `clk` cycles arms the transfer. The eight following falling edges then produce an update even though `frame_n` is back high.
- R6: In dual mode the word is {all-off bit 7, bank-A select bit 6 (active low), bank-B select bit 5 (active low), unused bit 4, address bits 3..0}. With bit 7 = 0 and both selects = 0, address n sets bit n of both `sw_a` and `sw_b` and clears all their other bits.
- R7: When the all-off bit is 1, every selected bank clears to all zeros.
- R8: In dual mode, when both selects are 1, both banks keep their previous values.
- R9: In dual mode, when exactly one select is 0, only that bank loads its new value and the other bank keeps its old value.
- R10: Falling edges after the eighth in the same frame are ignored until `frame_n` goes high and then low again. The next transfer then works normally.
- R11: In 32-channel mode the word is {all-off bit 7, select bit 6 (active low), unused bit 5, address bits 4..0}. With select = 0 and all-off = 0, address n sets only bit n of `sw_a`. With select = 1, `sw_a` is kept.
- R12: The unused bit (bit 4 in dual mode, bit 5 in 32-channel mode) has no effect on the outputs.
- R13: `sw_a` and `sw_b` each have at most one bit set at all times. In 32-channel mode `sw_b` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low transfer frame / arm input |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdata | input | 1 | Serial data, MSB first |
| sw_a | output | CH_A (16 dual / 32 single) | One-hot switch enables, bank A (or the single bank) |
| sw_b | output | CH_B (16) | One-hot switch enables, bank B; zero in 32-channel mode |

## Verification
The assertions assume that `frame_n`, `sclk` and `sdata` are synchronous to `clk`. They also assume that `sclk` holds each level for at least one cycle and that `sdata` is steady when a falling edge is sampled. Under those conditions, an output change can only follow a COMMIT cycle, and the HOLD and IDLE states stay put as the requirements describe. The stimulus drives every input on the falling edge of `clk`. It holds each serial-clock level for two cycles and changes `sdata` only together with the rising serial clock. It moves `frame_n` only while `sclk` is low and steady, so no edge is lost or counted twice.

// File: rtl/mux_sel_pkg.sv
package mux_sel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_HOLD   = 2'd3
    } ser_state_e;

    localparam int WORD_W   = 8;
    localparam int EN_BIT   = 7;
    localparam int SELA_BIT = 6;
    localparam int SELB_BIT = 5;

endpackage

// File: rtl/ser_frontend.sv
module ser_frontend
    import mux_sel_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             sclk,
    input  logic             sdata,
    output logic [W-1:0]     word,
    output logic             commit,
    output ser_state_e       state
);

    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    ser_state_e       nxt;
    logic             sclk_q;
    logic             fall;
    logic             last_edge;
    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] cnt;

    assign fall      = sclk_q && !sclk;
    assign last_edge = (state == ST_SHIFT) && fall && (cnt == LAST);
    assign commit    = (state == ST_COMMIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!frame_n)  nxt = ST_SHIFT;
            ST_SHIFT:  if (last_edge) nxt = ST_COMMIT;
            ST_COMMIT:                nxt = ST_HOLD;
            ST_HOLD:   if (frame_n)   nxt = ST_IDLE;
            default:                  nxt = ST_IDLE;
        endcase
    end

    // shift path and edge counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            shreg  <= '0;
            cnt    <= '0;
            word   <= '0;
        end else begin
            sclk_q <= sclk;
            if (state == ST_IDLE) begin
                cnt <= '0;
            end else if (state == ST_SHIFT && fall) begin
                shreg <= {shreg[W-2:0], sdata};
                cnt   <= cnt + 1'b1;
                if (cnt == LAST) word <= {shreg[W-2:0], sdata};
            end
        end
    end

endmodule

// File: rtl/word_decoder.sv
module word_decoder
    import mux_sel_pkg::*;
#(
    parameter bit DUAL_BANK = 1'b1,
    parameter int CH_A      = 16,
    parameter int CH_B      = 16
) (
    input  logic [WORD_W-1:0] word,
    output logic              upd_a,
    output logic              upd_b,
    output logic [CH_A-1:0]   nxt_a,
    output logic [CH_B-1:0]   nxt_b
);

    localparam int ADDR_W = $clog2(CH_A);

    logic              all_off;
    logic [ADDR_W-1:0] addr;

    assign all_off = word[EN_BIT];
    assign addr    = word[ADDR_W-1:0];
    assign upd_a   = !word[SELA_BIT];

    for (genvar i = 0; i < CH_A; i++) begin : g_chan_a
        assign nxt_a[i] = !all_off && (addr == ADDR_W'(i));
    end

    if (DUAL_BANK) begin : g_dual
        assign upd_b = !word[SELB_BIT];
        for (genvar j = 0; j < CH_B; j++) begin : g_chan_b
            assign nxt_b[j] = !all_off && (addr == ADDR_W'(j));
        end
    end else begin : g_single
        assign upd_b = 1'b0;
        assign nxt_b = '0;
    end

endmodule

// File: rtl/bank_reg.sv
module bank_reg #(
    parameter int CH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CH-1:0] nxt,
    output logic [CH-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= nxt;
    end

endmodule

// File: rtl/serial_mux_ctl.sv
module serial_mux_ctl
    import mux_sel_pkg::*;
#(
    parameter bit DUAL_BANK = 1'b1,
    parameter int CH_A      = DUAL_BANK ? 16 : 32,
    parameter int CH_B      = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_n,
    input  logic            sclk,
    input  logic            sdata,
    output logic [CH_A-1:0] sw_a,
    output logic [CH_B-1:0] sw_b
);

    logic [WORD_W-1:0] word;
    logic              commit;
    ser_state_e        fe_state;
    logic              upd_a;
    logic              upd_b;
    logic [CH_A-1:0]   nxt_a;
    logic [CH_B-1:0]   nxt_b;

    ser_frontend #(.W(WORD_W)) u_fe (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .sclk    (sclk),
        .sdata   (sdata),
        .word    (word),
        .commit  (commit),
        .state   (fe_state)
    );

    word_decoder #(.DUAL_BANK(DUAL_BANK), .CH_A(CH_A), .CH_B(CH_B)) u_dec (
        .word  (word),
        .upd_a (upd_a),
        .upd_b (upd_b),
        .nxt_a (nxt_a),
        .nxt_b (nxt_b)
    );

    bank_reg #(.CH(CH_A)) u_bank_a (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (commit && upd_a),
        .nxt   (nxt_a),
        .q     (sw_a)
    );

    if (DUAL_BANK) begin : g_bank_b
        bank_reg #(.CH(CH_B)) u_bank_b (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (commit && upd_b),
            .nxt   (nxt_b),
            .q     (sw_b)
        );
    end else begin : g_no_bank_b
        assign sw_b = '0;
    end

endmodule

// File: rtl/mux_sel_chk.sv
module mux_sel_chk
    import mux_sel_pkg::*;
#(
    parameter int CH_A = 16,
    parameter int CH_B = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_n,
    input logic            commit,
    input ser_state_e      state,
    input logic [CH_A-1:0] sw_a,
    input logic [CH_B-1:0] sw_b
);

    // R13
    onehot_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_a));

    // R13
    onehot_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_b));

    // R4
    gate_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sw_a) |-> $past(commit));

    // R4
    gate_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sw_b) |-> $past(commit));

    // R4
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R10
    hold_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !frame_n) |=> (state == ST_HOLD));

    // R2
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && frame_n) |=> (state == ST_IDLE));

endmodule

bind serial_mux_ctl mux_sel_chk #(.CH_A(CH_A), .CH_B(CH_B)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_n (frame_n),
    .commit  (commit),
    .state   (fe_state),
    .sw_a    (sw_a),
    .sw_b    (sw_b)
);

// File: tb/sim_serial_mux_ctl.sv
module sim_serial_mux_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    // word, dual bank A, dual bank B, single bank
    localparam logic [7:0]  V_WORD [NVEC] = '{8'h03, 8'h1F, 8'h45, 8'h2A, 8'h60,
                                             8'hA0, 8'h11, 8'hC7, 8'h80, 8'h00};
    localparam logic [15:0] V_DA   [NVEC] = '{16'h0008, 16'h8000, 16'h8000, 16'h0400, 16'h0400,
                                             16'h0000, 16'h0002, 16'h0002, 16'h0000, 16'h0001};
    localparam logic [15:0] V_DB   [NVEC] = '{16'h0008, 16'h8000, 16'h0020, 16'h0020, 16'h0020,
                                             16'h0020, 16'h0002, 16'h0000, 16'h0000, 16'h0001};
    localparam logic [31:0] V_S    [NVEC] = '{32'h0000_0008, 32'h8000_0000, 32'h8000_0000,
                                             32'h0000_0400, 32'h0000_0400, 32'h0000_0000,
                                             32'h0002_0000, 32'h0002_0000, 32'h0000_0000,
                                             32'h0000_0001};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1'b1;
    logic sclk = 1'b0;
    logic sdata = 1'b0;
    logic [15:0] d_a, d_b;
    logic [31:0] s_a;
    logic [15:0] s_b;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_mux_ctl #(.DUAL_BANK(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sclk(sclk), .sdata(sdata),
        .sw_a(d_a), .sw_b(d_b)
    );

    serial_mux_ctl #(.DUAL_BANK(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sclk(sclk), .sdata(sdata),
        .sw_a(s_a), .sw_b(s_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [15:0] ea, input logic [15:0] eb,
                             input logic [31:0] es);
        chk({req, " dual A"}, {16'h0, d_a}, {16'h0, ea});
        chk({req, " dual B"}, {16'h0, d_b}, {16'h0, eb});
        chk({req, " single"}, s_a, es);
        chk({req, " R13 single B"}, {16'h0, s_b}, 32'h0);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        sclk = 1'b1;
        sdata = b;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_word(input logic [7:0] w);
        @(negedge clk);
        frame_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 7; i >= 0; i--) send_bit(w[i]);
        frame_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] w;
        repeat (3) @(negedge clk);
        // R1 during reset
        check_all("R1 in reset", 16'h0, 16'h0, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R1 after release", 16'h0, 16'h0, 32'h0);

        // vector table: R3 R6 R7 R8 R9 R11 R12
        for (int v = 0; v < NVEC; v++) begin
            send_word(V_WORD[v]);
            check_all($sformatf("R3 R6 R7 R8 R9 R11 R12 vec%0d", v), V_DA[v], V_DB[v], V_S[v]);
        end

        // R4: no update after seven edges, update after the eighth with frame still low
        w = 8'h05;
        @(negedge clk);
        frame_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 7; i >= 1; i--) send_bit(w[i]);
        check_all("R4 seven edges", 16'h0001, 16'h0001, 32'h0000_0001);
        send_bit(w[0]);
        check_all("R4 eighth edge", 16'h0020, 16'h0020, 32'h0000_0020);

        // R10: extra edges in the same frame ignored
        w = 8'h0F;
        for (int i = 7; i >= 0; i--) send_bit(w[i]);
        check_all("R10 extra edges", 16'h0020, 16'h0020, 32'h0000_0020);
        frame_n = 1'b1;
        repeat (2) @(negedge clk);
        send_word(8'h0F);
        check_all("R10 rearm", 16'h8000, 16'h8000, 32'h0000_8000);

        // R5: brief frame pulse arms the count
        w = 8'h09;
        @(negedge clk);
        frame_n = 1'b0;
        repeat (2) @(negedge clk);
        frame_n = 1'b1;
        for (int i = 7; i >= 0; i--) send_bit(w[i]);
        repeat (2) @(negedge clk);
        check_all("R5 brief pulse", 16'h0200, 16'h0200, 32'h0000_0200);

        // R2: edges with frame high are not counted
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        check_all("R2 idle edges", 16'h0200, 16'h0200, 32'h0000_0200);
        send_word(8'h02);
        check_all("R2 next word", 16'h0004, 16'h0004, 32'h0000_0004);

        // R1: reset in mid operation
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R1 mid reset", 16'h0, 16'h0, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        send_word(8'h1E);
        check_all("R1 R6 after reset", 16'h4000, 16'h4000, 32'h4000_0000);

        finish_run();
    end

endmodule